// File: doc/BRIEF.md
# Pipelined Three-Stage Dot-Product Chain

This block computes the dot product of two three-element signed vectors, one new vector pair per clock. Three processing elements sit in a row. Each one owns a single lane of operands. A running partial sum walks from the first element through the second to the third, and each element adds its own lane product on the way.

Inside each element the work is split over two clock cycles. The multiplier writes into a product register. In the following cycle the adder combines that registered product with the partial sum arriving from the element before it. The block delays each lane's operands internally by its position in the row, so that the incoming partial sum and the local product are ready in the same cycle. As a result the user presents all three operand pairs together in one cycle.

A valid bit travels beside the data through every register stage. The result comes out with its own valid flag after a fixed latency. While no result is valid, the result port holds the last valid sum.

Top module: `dp_chain`

## Requirements
- R1: An active-low asynchronous reset `rst_n` clears `out_valid` and `out_sum` to zero. Results already in flight are discarded.
- R2: The result equals the signed sum of the lane products a0*b0 + a1*b1 + a2*b2. Lane i is taken from `in_a[8*i+7:8*i]` and `in_b[8*i+7:8*i]`, and both are read as two's complement.
- R3: A vector sampled at a rising edge appears on `out_valid`/`out_sum` right after the sixth rising edge, counting the sampling edge as the first. `out_valid` stays low until then.
- R4: A new vector is accepted at every rising edge. Back-to-back inputs yield results on consecutive cycles, in input order.
- R5: The pattern of `out_valid` repeats the pattern of `in_valid` with the fixed latency. No result is lost or duplicated.
- R6: Extreme operands give exact sums with no wraparound in the 18-bit result: all lanes at -128 by -128 give 49152, and all lanes at -128 by 127 give -48768.
- R7: While `out_valid` is low, `out_sum` keeps the last valid result. Operands presented with `in_valid` low have no effect on any result.
- R8: In every element after the first, the partial sum arriving from the element before it is valid in exactly the cycle in which the element's own product register is valid.
- R9: Lanes with mixed operand signs, including zero operands, add with correct signs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the operand buses as a vector to process |
| in_a | input | 24 | First operand of each lane, lane i at bits 8i+7..8i, signed |
| in_b | input | 24 | Second operand of each lane, lane i at bits 8i+7..8i, signed |
| out_valid | output | 1 | High for one cycle per finished result |
| out_sum | output | 18 | Signed dot product, held while out_valid is low |

## Verification
The bench first applies one isolated vector. This pins down the exact output cycle and shows the output stays quiet beforehand. It then streams vectors that differ at every position without gaps, so any lane skew that pairs a partial sum with the wrong product shows up as a wrong sum. The full-scale patterns separate correct sign extension and width from wraparound. A sparse valid pattern carries junk operands in the idle slots, which shows that invalid slots neither produce results nor disturb the held sum. A reset applied while results are in flight confirms they are dropped.

// File: rtl/dp_chain_pkg.sv
`timescale 1ns/1ps
package dp_chain_pkg;

    localparam int DEF_LANES = 3;
    localparam int DEF_OPW   = 8;
    localparam int DEF_SUMW  = 18;

    // registers from the input capture to the result register:
    // capture, product of lane 0, one adder per lane, result
    function automatic int pipe_depth(input int lanes);
        return lanes + 3;
    endfunction

    function automatic int prod_width(input int opw);
        return 2 * opw;
    endfunction

endpackage

// File: rtl/dp_skew.sv
`timescale 1ns/1ps
// Delay line that lines up one lane's operands with the partial sum
module dp_skew #(
    parameter int W     = 16,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_data,
    output logic         out_v,
    output logic [W-1:0] out_data
);

    logic [W-1:0]     stage_q [DEPTH];
    logic [DEPTH-1:0] stage_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                stage_q[k] <= '0;
            end
            stage_v <= '0;
        end else begin
            stage_q[0] <= in_data;
            stage_v[0] <= in_v;
            for (int k = 1; k < DEPTH; k++) begin
                stage_q[k] <= stage_q[k-1];
                stage_v[k] <= stage_v[k-1];
            end
        end
    end

    assign out_data = stage_q[DEPTH-1];
    assign out_v    = stage_v[DEPTH-1];

endmodule

// File: rtl/dp_pe.sv
`timescale 1ns/1ps
// One element: multiply into a register, then add in the next cycle
module dp_pe #(
    parameter int OPW  = 8,
    parameter int SUMW = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_v,
    input  logic signed [OPW-1:0]  op_a,
    input  logic signed [OPW-1:0]  op_b,
    input  logic signed [SUMW-1:0] acc_in,
    output logic                   prod_v,
    output logic signed [SUMW-1:0] acc_out,
    output logic                   acc_v
);

    localparam int PW = dp_chain_pkg::prod_width(OPW);

    logic signed [PW-1:0]   prod_q;
    logic signed [SUMW-1:0] prod_ext;

    // multiply stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod_q <= '0;
            prod_v <= 1'b0;
        end else begin
            prod_q <= PW'(op_a) * PW'(op_b);
            prod_v <= op_v;
        end
    end

    assign prod_ext = SUMW'(prod_q);

    // accumulate stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_out <= '0;
            acc_v   <= 1'b0;
        end else begin
            acc_out <= acc_in + prod_ext;
            acc_v   <= prod_v;
        end
    end

endmodule

// File: rtl/dp_chain.sv
`timescale 1ns/1ps
module dp_chain #(
    parameter int LANES = dp_chain_pkg::DEF_LANES,
    parameter int OPW   = dp_chain_pkg::DEF_OPW,
    parameter int SUMW  = dp_chain_pkg::DEF_SUMW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*OPW-1:0]   in_a,
    input  logic [LANES*OPW-1:0]   in_b,
    output logic                   out_valid,
    output logic signed [SUMW-1:0] out_sum
);

    localparam int BUSW = LANES * OPW;

    // input capture
    logic            cap_v;
    logic [BUSW-1:0] cap_a;
    logic [BUSW-1:0] cap_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_v <= 1'b0;
            cap_a <= '0;
            cap_b <= '0;
        end else begin
            cap_v <= in_valid;
            cap_a <= in_a;
            cap_b <= in_b;
        end
    end

    logic signed [SUMW-1:0] acc   [LANES];
    logic [LANES-1:0]       acc_v;
    logic [LANES-1:0]       prod_v;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic                   op_v;
        logic signed [OPW-1:0]  op_a;
        logic signed [OPW-1:0]  op_b;
        logic signed [SUMW-1:0] acc_src;

        if (i == 0) begin : g_head
            assign op_v    = cap_v;
            assign op_a    = cap_a[OPW-1:0];
            assign op_b    = cap_b[OPW-1:0];
            assign acc_src = '0;
        end else begin : g_tail
            logic [2*OPW-1:0] sk_data;
            dp_skew #(
                .W     (2*OPW),
                .DEPTH (i)
            ) u_skew (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_v     (cap_v),
                .in_data  ({cap_a[i*OPW +: OPW], cap_b[i*OPW +: OPW]}),
                .out_v    (op_v),
                .out_data (sk_data)
            );
            assign op_a    = sk_data[2*OPW-1:OPW];
            assign op_b    = sk_data[OPW-1:0];
            assign acc_src = acc[i-1];
        end

        dp_pe #(
            .OPW  (OPW),
            .SUMW (SUMW)
        ) u_pe (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_v    (op_v),
            .op_a    (op_a),
            .op_b    (op_b),
            .acc_in  (acc_src),
            .prod_v  (prod_v[i]),
            .acc_out (acc[i]),
            .acc_v   (acc_v[i])
        );
    end

    // result register, holds the last valid sum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= acc_v[LANES-1];
            if (acc_v[LANES-1]) begin
                out_sum <= acc[LANES-1];
            end
        end
    end

endmodule

// File: rtl/dp_chain_chk.sv
`timescale 1ns/1ps
module dp_chain_chk #(
    parameter int LANES = dp_chain_pkg::DEF_LANES,
    parameter int OPW   = dp_chain_pkg::DEF_OPW,
    parameter int SUMW  = dp_chain_pkg::DEF_SUMW
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [LANES*OPW-1:0]   in_a,
    input logic [LANES*OPW-1:0]   in_b,
    input logic                   out_valid,
    input logic signed [SUMW-1:0] out_sum,
    input logic [LANES-1:0]       prod_v,
    input logic [LANES-1:0]       acc_v
);

    localparam int LAT = dp_chain_pkg::pipe_depth(LANES);
    localparam int PW  = dp_chain_pkg::prod_width(OPW);

    // cycles since reset release, saturating at the latency
    logic [7:0] settle;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle <= '0;
        end else if (settle < 8'(LAT)) begin
            settle <= settle + 8'd1;
        end
    end

    logic signed [SUMW-1:0] ref_sum;
    always_comb begin
        logic signed [PW-1:0] p;
        ref_sum = '0;
        p       = '0;
        for (int i = 0; i < LANES; i++) begin
            p = PW'(signed'(in_a[i*OPW +: OPW])) * PW'(signed'(in_b[i*OPW +: OPW]));
            ref_sum = ref_sum + SUMW'(p);
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_sum == '0));

    p_sum_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (settle == 8'(LAT) && out_valid) |-> out_sum == $past(ref_sum, LAT));

    p_valid_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (settle == 8'(LAT)) |-> out_valid == $past(in_valid, LAT));

    p_quiet_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (settle < 8'(LAT)) |-> !out_valid);

    p_hold_sum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sum));

    for (genvar i = 1; i < LANES; i++) begin : g_align
        p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
            prod_v[i] == acc_v[i-1]);
    end

endmodule

bind dp_chain dp_chain_chk #(
    .LANES (LANES),
    .OPW   (OPW),
    .SUMW  (SUMW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_sum   (out_sum),
    .prod_v    (prod_v),
    .acc_v     (acc_v)
);

// File: tb/sim_dp_chain.sv
`timescale 1ns/1ps
module sim_dp_chain;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic [23:0]              in_a = '0;
    logic [23:0]              in_b = '0;
    logic                     out_valid;
    logic signed [17:0]       out_sum;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int hold_sum = 0;

    logic signed [7:0] va [0:31][0:2];
    logic signed [7:0] vb [0:31][0:2];
    logic              vv [0:31];

    always #2.5 clk = ~clk;

    dp_chain u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int dot(input int idx);
        int s = 0;
        for (int l = 0; l < 3; l++) s += int'(va[idx][l]) * int'(vb[idx][l]);
        return s;
    endfunction

    task automatic drive(input int idx);
        for (int l = 0; l < 3; l++) begin
            in_a[l*8 +: 8] = va[idx][l];
            in_b[l*8 +: 8] = vb[idx][l];
        end
        in_valid = vv[idx];
    endtask

    // drives n slots from the arrays and checks every output slot
    task automatic run_stream(input int n, input string req, output int n_out);
        n_out = 0;
        for (int cyc = 0; cyc < n + 6; cyc++) begin
            @(negedge clk);
            if (cyc < 6) begin
                if (cyc > 0) chk(out_valid == 1'b0, {req, " R3 early valid"}, int'(out_valid), 0);
            end else begin
                int idx = cyc - 6;
                chk(out_valid == vv[idx], {req, " R5 valid pattern"}, int'(out_valid), int'(vv[idx]));
                if (out_valid) n_out++;
                if (vv[idx]) hold_sum = dot(idx);
                chk(int'(out_sum) == hold_sum, {req, " sum"}, int'(out_sum), hold_sum);
            end
            if (cyc < n) drive(cyc);
            else in_valid = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        chk(int'(out_sum) == 0, "R1 reset sum", int'(out_sum), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_single();
        int n;
        va[0] = '{8'sd3, 8'sd5, -8'sd7}; vb[0] = '{8'sd4, 8'sd6, 8'sd2}; vv[0] = 1'b1;
        run_stream(1, "R2 R3 single", n);
        chk(hold_sum == 28, "R2 single value", hold_sum, 28);
    endtask

    task automatic t_stream();
        int n;
        for (int k = 0; k < 12; k++) begin
            for (int l = 0; l < 3; l++) begin
                va[k][l] = 8'((k * 37 + l * 59 + 11) % 256);
                vb[k][l] = 8'((k * 83 + l * 23 + 101) % 256);
            end
            vv[k] = 1'b1;
        end
        run_stream(12, "R4 R8 stream", n);
        chk(n == 12, "R4 result count", n, 12);
    endtask

    task automatic t_extreme();
        int n;
        va[0] = '{-8'sd128, -8'sd128, -8'sd128}; vb[0] = '{-8'sd128, -8'sd128, -8'sd128}; vv[0] = 1'b1;
        va[1] = '{-8'sd128, -8'sd128, -8'sd128}; vb[1] = '{8'sd127, 8'sd127, 8'sd127};    vv[1] = 1'b1;
        va[2] = '{8'sd127, 8'sd127, 8'sd127};    vb[2] = '{8'sd127, 8'sd127, 8'sd127};    vv[2] = 1'b1;
        run_stream(3, "R6 extreme", n);
        chk(dot(0) == 49152, "R6 max positive", dot(0), 49152);
        chk(dot(1) == -48768, "R6 max negative", dot(1), -48768);
    endtask

    task automatic t_mixed();
        int n;
        va[0] = '{-8'sd9, 8'sd0, 8'sd100};  vb[0] = '{8'sd12, -8'sd77, -8'sd3};  vv[0] = 1'b1;
        va[1] = '{8'sd1, -8'sd1, 8'sd0};    vb[1] = '{-8'sd1, -8'sd1, 8'sd0};    vv[1] = 1'b1;
        va[2] = '{-8'sd50, -8'sd60, 8'sd70}; vb[2] = '{-8'sd2, 8'sd3, -8'sd4};   vv[2] = 1'b1;
        run_stream(3, "R9 mixed", n);
    endtask

    task automatic t_gaps();
        int n;
        bit pat [0:9] = '{1, 0, 0, 1, 0, 1, 1, 0, 0, 1};
        int want = 0;
        for (int k = 0; k < 10; k++) begin
            for (int l = 0; l < 3; l++) begin
                va[k][l] = 8'((k * 71 + l * 13 + 7) % 256);
                vb[k][l] = pat[k] ? 8'((k * 19 + l * 41 + 3) % 256) : 8'sd127;
            end
            vv[k] = pat[k];
            if (pat[k]) want++;
        end
        run_stream(10, "R7 R5 gaps", n);
        chk(n == want, "R5 valid count", n, want);
    endtask

    task automatic t_reset_flight();
        for (int k = 0; k < 3; k++) begin
            va[k] = '{8'sd10, 8'sd20, 8'sd30}; vb[k] = '{8'sd1, 8'sd1, 8'sd1}; vv[k] = 1'b1;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            drive(k);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 flight valid", int'(out_valid), 0);
        chk(int'(out_sum) == 0, "R1 flight sum", int'(out_sum), 0);
        rst_n = 1'b1;
        hold_sum = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1 dropped result", int'(out_valid), 0);
        end
        chk(int'(out_sum) == 0, "R1 sum after drop", int'(out_sum), 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_stream();
        t_extreme();
        t_mixed();
        t_gaps();
        t_reset_flight();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule